// File: doc/BRIEF.md
# Virtual supervisor interrupt pending aggregator

This block forms the machine-level pending bits that a virtualized supervisor guest sees. Four pending bits are produced. The virtual external bit merges three sources: a software-injected bit, one guest-external line picked by a selector, and a platform line. The virtual timer bit fires when an offset-adjusted copy of the real-time counter reaches the guest's compare value, or when software injects it. The supervisor guest-external bit is raised when any enabled guest-external line is pending. The virtual software bit follows its injected source.

All four bits are registered once per clock and cleared by reset. They are also presented as a packed hypervisor-view word in which they occupy their standard interrupt positions and can only be read. Address decode, trap entry and priority arbitration are handled by neighbouring logic.

Top module: `vsip_pend_agg`

## Requirements
- R1: While reset (rst_n low) is applied, vssip_o, vstip_o, vseip_o, sgeip_o and hview_o are all zero.
- R2: vseip_o is the OR of inj_vseip, plat_vseip and the guest-external line chosen by gext_sel. Any one of the three sources alone sets it.
- R3: For a gext_sel value k with 1 <= k <= GUEST_LINES, the chosen line is gext_pend[k], whatever gext_en holds. A gext_sel value of 0, or any value above GUEST_LINES, chooses no line.
- R4: vstip_o is the OR of inj_vstip and the condition (rt_count + time_ofs) >= vt_cmp. The sum is taken modulo 2^64 and the comparison is unsigned.
- R5: sgeip_o is the OR over bits 1..GUEST_LINES of (gext_pend AND gext_en). Bit 0 of both vectors never contributes.
- R6: vssip_o follows inj_vssip.
- R7: hview_o carries vssip_o in bit 2, vstip_o in bit 6, vseip_o in bit 10 and sgeip_o in bit 12. All its other bits are zero.
- R8: Each output reflects the inputs sampled at the preceding rising clock edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_vssip | input | 1 | Software-injected virtual software pending |
| inj_vstip | input | 1 | Software-injected virtual timer pending |
| inj_vseip | input | 1 | Software-injected virtual external pending |
| plat_vseip | input | 1 | Platform virtual external interrupt line |
| gext_pend | input | GUEST_LINES+1 | Guest-external pending vector, bit 0 unused |
| gext_en | input | GUEST_LINES+1 | Guest-external enable vector, bit 0 unused |
| gext_sel | input | SEL_W | Guest-external line selector |
| rt_count | input | TIME_W | Real-time counter |
| time_ofs | input | TIME_W | Guest time offset |
| vt_cmp | input | TIME_W | Virtual timer compare value |
| vssip_o | output | 1 | Virtual software pending |
| vstip_o | output | 1 | Virtual timer pending |
| vseip_o | output | 1 | Virtual external pending |
| sgeip_o | output | 1 | Supervisor guest-external pending |
| hview_o | output | 13 | Read-only hypervisor view of the pending bits |

## Verification
The first set of patterns drives each term of the virtual external OR on its own. This separates a missing source from a wrongly picked guest line. Selector values of 0, of GUEST_LINES, of one past it and of the all-ones value are each paired with pending lines that would show a wrong pick. Enable-only and bit-0-only patterns separate the guest-external reduction from the selector path. Timer patterns test equality, a value one below the compare, an offset sum that wraps past 2^64 and a counter with its top bit set, which separate a wrapping unsigned compare from a widened or signed one.

// File: rtl/vsip_pkg.sv
package vsip_pkg;
   localparam int HV_W       = 13;
   localparam int HV_SSI_BIT = 2;
   localparam int HV_STI_BIT = 6;
   localparam int HV_SEI_BIT = 10;
   localparam int HV_GEI_BIT = 12;

   typedef struct packed {
      logic sgeip;
      logic vseip;
      logic vstip;
      logic vssip;
   } pend_t;

   localparam int PEND_W = $bits(pend_t);
endpackage

// File: rtl/vsip_gext_unit.sv
module vsip_gext_unit #(
   parameter int GUEST_LINES = 5,
   parameter int SEL_W       = 6
) (
   input  logic [GUEST_LINES:1] pend,
   input  logic [GUEST_LINES:1] en,
   input  logic [SEL_W-1:0]     sel,
   output logic                 sel_hit,
   output logic                 any_enabled
);
   logic [GUEST_LINES:1] pick;

   for (genvar k = 1; k <= GUEST_LINES; k++) begin : g_line
      assign pick[k] = (sel == SEL_W'(k)) & pend[k];
   end

   assign sel_hit     = |pick;
   assign any_enabled = |(pend & en);
endmodule

// File: rtl/vsip_timer_cmp.sv
module vsip_timer_cmp #(
   parameter int TIME_W = 64
) (
   input  logic [TIME_W-1:0] count,
   input  logic [TIME_W-1:0] offset,
   input  logic [TIME_W-1:0] compare,
   output logic              reached
);
   logic [TIME_W-1:0] guest_time;

   always_comb begin
      guest_time = count + offset;
      reached    = (guest_time >= compare);
   end
endmodule

// File: rtl/vsip_pend_regs.sv
module vsip_pend_regs
   import vsip_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  pend_t nxt,
   output pend_t cur
);
   logic [PEND_W-1:0] nxt_v, cur_v;

   assign nxt_v = nxt;

   for (genvar b = 0; b < PEND_W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cur_v[b] <= 1'b0;
         else        cur_v[b] <= nxt_v[b];
      end
   end

   assign cur = cur_v;
endmodule

// File: rtl/vsip_pend_agg.sv
module vsip_pend_agg
   import vsip_pkg::*;
#(
   parameter int GUEST_LINES = 5,
   parameter int SEL_W       = 6,
   parameter int TIME_W      = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   inj_vssip,
   input  logic                   inj_vstip,
   input  logic                   inj_vseip,
   input  logic                   plat_vseip,
   input  logic [GUEST_LINES:0]   gext_pend,
   input  logic [GUEST_LINES:0]   gext_en,
   input  logic [SEL_W-1:0]       gext_sel,
   input  logic [TIME_W-1:0]      rt_count,
   input  logic [TIME_W-1:0]      time_ofs,
   input  logic [TIME_W-1:0]      vt_cmp,
   output logic                   vssip_o,
   output logic                   vstip_o,
   output logic                   vseip_o,
   output logic                   sgeip_o,
   output logic [HV_W-1:0]        hview_o
);
   if (GUEST_LINES < 1 || GUEST_LINES > 63) begin : g_bad_lines
      $error("GUEST_LINES must lie in 1..63");
   end
   if (SEL_W < $clog2(GUEST_LINES + 1)) begin : g_bad_sel
      $error("SEL_W too narrow for GUEST_LINES");
   end
   if (TIME_W < 1) begin : g_bad_time
      $error("TIME_W must be positive");
   end

   logic  unused_bit0;
   logic  sel_hit, any_enabled, reached;
   pend_t nxt, cur;

   assign unused_bit0 = gext_pend[0] ^ gext_en[0];

   vsip_gext_unit #(.GUEST_LINES(GUEST_LINES), .SEL_W(SEL_W)) u_gext (
      .pend        (gext_pend[GUEST_LINES:1]),
      .en          (gext_en[GUEST_LINES:1]),
      .sel         (gext_sel),
      .sel_hit     (sel_hit),
      .any_enabled (any_enabled)
   );

   vsip_timer_cmp #(.TIME_W(TIME_W)) u_tmr (
      .count   (rt_count),
      .offset  (time_ofs),
      .compare (vt_cmp),
      .reached (reached)
   );

   always_comb begin
      nxt.vssip = inj_vssip;
      nxt.vstip = inj_vstip | reached;
      nxt.vseip = inj_vseip | plat_vseip | sel_hit;
      nxt.sgeip = any_enabled;
   end

   vsip_pend_regs u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .nxt   (nxt),
      .cur   (cur)
   );

   assign vssip_o = cur.vssip;
   assign vstip_o = cur.vstip;
   assign vseip_o = cur.vseip;
   assign sgeip_o = cur.sgeip;

   always_comb begin
      hview_o             = '0;
      hview_o[HV_SSI_BIT] = cur.vssip;
      hview_o[HV_STI_BIT] = cur.vstip;
      hview_o[HV_SEI_BIT] = cur.vseip;
      hview_o[HV_GEI_BIT] = cur.sgeip;
   end
endmodule

// File: rtl/vsip_pend_agg_chk.sv
module vsip_pend_agg_chk #(
   parameter int GUEST_LINES = 5,
   parameter int SEL_W       = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 inj_vssip,
   input logic                 inj_vstip,
   input logic                 inj_vseip,
   input logic                 plat_vseip,
   input logic [GUEST_LINES:0] gext_pend,
   input logic [GUEST_LINES:0] gext_en,
   input logic [SEL_W-1:0]     gext_sel,
   input logic                 vssip_o,
   input logic                 vstip_o,
   input logic                 vseip_o,
   input logic                 sgeip_o,
   input logic [12:0]          hview_o
);
   logic no_line;
   assign no_line = (gext_sel == '0) || (gext_sel > SEL_W'(GUEST_LINES));

   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (!vssip_o && !vstip_o && !vseip_o && !sgeip_o && hview_o == '0));

   a_r2_direct_vse: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_vseip || plat_vseip) |=> vseip_o);

   a_r3_no_line: assert property (@(posedge clk) disable iff (!rst_n)
      (no_line && !inj_vseip && !plat_vseip) |=> !vseip_o);

   a_r4_inject_vst: assert property (@(posedge clk) disable iff (!rst_n)
      inj_vstip |=> vstip_o);

   a_r5_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      ((gext_pend[GUEST_LINES:1] & gext_en[GUEST_LINES:1]) == '0) |=> !sgeip_o);

   a_r6_vss_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (vssip_o == $past(inj_vssip)));

   a_r7_view_map: assert property (@(posedge clk) disable iff (!rst_n)
      (hview_o == {sgeip_o, 1'b0, vseip_o, 3'b000, vstip_o, 3'b000, vssip_o, 2'b00}));
endmodule

bind vsip_pend_agg vsip_pend_agg_chk #(.GUEST_LINES(GUEST_LINES), .SEL_W(SEL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .inj_vssip  (inj_vssip),
   .inj_vstip  (inj_vstip),
   .inj_vseip  (inj_vseip),
   .plat_vseip (plat_vseip),
   .gext_pend  (gext_pend),
   .gext_en    (gext_en),
   .gext_sel   (gext_sel),
   .vssip_o    (vssip_o),
   .vstip_o    (vstip_o),
   .vseip_o    (vseip_o),
   .sgeip_o    (sgeip_o),
   .hview_o    (hview_o)
);

// File: tb/vsip_pend_agg_tb_top.sv
`timescale 1ns/1ps
module vsip_pend_agg_tb_top;
   localparam int GL = 5;
   localparam int SW = 6;
   localparam int TW = 64;
   localparam logic [TW-1:0] MAXT = {TW{1'b1}};

   typedef struct packed {
      logic          ss, ts, es, plat;
      logic [GL:0]   pend, en;
      logic [SW-1:0] sel;
      logic [TW-1:0] tm, ofs, cmp;
      logic [3:0]    ex;      // {sgeip, vseip, vstip, vssip}
   } vec_t;

   localparam int NV = 18;
   localparam vec_t TBL [NV] = '{
      '{0,0,0,0, 6'h00, 6'h00, 6'd0,  64'd0, 64'd0, MAXT, 4'b0000}, // idle
      '{1,0,0,0, 6'h00, 6'h00, 6'd0,  64'd0, 64'd0, MAXT, 4'b0001}, // R6
      '{0,0,1,0, 6'h00, 6'h00, 6'd0,  64'd0, 64'd0, MAXT, 4'b0100}, // R2 inject
      '{0,0,0,1, 6'h00, 6'h00, 6'd0,  64'd0, 64'd0, MAXT, 4'b0100}, // R2 platform
      '{0,0,0,0, 6'h04, 6'h00, 6'd2,  64'd0, 64'd0, MAXT, 4'b0100}, // R3 pick line 2
      '{0,0,0,0, 6'h04, 6'h00, 6'd3,  64'd0, 64'd0, MAXT, 4'b0000}, // R3 wrong line
      '{0,0,0,0, 6'h01, 6'h01, 6'd0,  64'd0, 64'd0, MAXT, 4'b0000}, // R5 bit0, R3 sel 0
      '{0,0,0,0, 6'h20, 6'h20, 6'd5,  64'd0, 64'd0, MAXT, 4'b1100}, // R3 top, R5
      '{0,0,0,0, 6'h3E, 6'h00, 6'd6,  64'd0, 64'd0, MAXT, 4'b0000}, // R3 one past
      '{0,0,0,0, 6'h3E, 6'h00, 6'd63, 64'd0, 64'd0, MAXT, 4'b0000}, // R3 all ones
      '{0,0,0,0, 6'h02, 6'h02, 6'd0,  64'd0, 64'd0, MAXT, 4'b1000}, // R5 alone
      '{0,0,0,0, 6'h00, 6'h3E, 6'd1,  64'd0, 64'd0, MAXT, 4'b0000}, // R5 enable only
      '{0,0,0,0, 6'h00, 6'h00, 6'd0,  64'd100, 64'd0, 64'd100, 4'b0010}, // R4 equal
      '{0,0,0,0, 6'h00, 6'h00, 6'd0,  64'd99,  64'd0, 64'd100, 4'b0000}, // R4 below
      '{0,0,0,0, 6'h00, 6'h00, 6'd0,  64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 64'h11, 4'b0000}, // R4 wrap
      '{0,0,0,0, 6'h00, 6'h00, 6'd0,  64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 64'h10, 4'b0010}, // R4 wrap eq
      '{0,0,0,0, 6'h00, 6'h00, 6'd0,  64'h8000_0000_0000_0000, 64'd0, 64'd1, 4'b0010}, // R4 unsigned
      '{1,1,1,0, 6'h3E, 6'h3E, 6'd1,  64'd0, 64'd0, MAXT, 4'b1111}  // all
   };

   logic clk = 0, rst_n = 0;
   logic inj_vssip = 0, inj_vstip = 0, inj_vseip = 0, plat_vseip = 0;
   logic [GL:0] gext_pend = '0, gext_en = '0;
   logic [SW-1:0] gext_sel = '0;
   logic [TW-1:0] rt_count = '0, time_ofs = '0, vt_cmp = MAXT;
   logic vssip_o, vstip_o, vseip_o, sgeip_o;
   logic [12:0] hview_o;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   vsip_pend_agg #(.GUEST_LINES(GL), .SEL_W(SW), .TIME_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .inj_vssip(inj_vssip), .inj_vstip(inj_vstip), .inj_vseip(inj_vseip),
      .plat_vseip(plat_vseip), .gext_pend(gext_pend), .gext_en(gext_en),
      .gext_sel(gext_sel), .rt_count(rt_count), .time_ofs(time_ofs),
      .vt_cmp(vt_cmp), .vssip_o(vssip_o), .vstip_o(vstip_o),
      .vseip_o(vseip_o), .sgeip_o(sgeip_o), .hview_o(hview_o)
   );

   function automatic logic [12:0] view_of(input logic [3:0] e);
      logic [12:0] v = '0;
      v[2] = e[0]; v[6] = e[1]; v[10] = e[2]; v[12] = e[3];
      return v;
   endfunction

   task automatic check(input string req, input logic [3:0] ex);
      logic [3:0] got;
      got = {sgeip_o, vseip_o, vstip_o, vssip_o};
      n_chk++;
      if (got !== ex) begin
         n_bad++;
         $display("FAIL %s pend got=%b exp=%b", req, got, ex);
      end
      n_chk++;
      if (hview_o !== view_of(ex)) begin
         n_bad++;
         $display("FAIL R7 (%s) view got=%h exp=%h", req, hview_o, view_of(ex));
      end
   endtask

   task automatic apply(input vec_t v);
      inj_vssip = v.ss; inj_vstip = v.ts; inj_vseip = v.es; plat_vseip = v.plat;
      gext_pend = v.pend; gext_en = v.en; gext_sel = v.sel;
      rt_count = v.tm; time_ofs = v.ofs; vt_cmp = v.cmp;
   endtask

   initial begin
      #4_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=hang exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: everything active during reset, outputs must stay clear
      apply(TBL[NV-1]);
      repeat (3) @(negedge clk);
      check("R1", 4'b0000);
      rst_n = 1;
      @(negedge clk);
      check("R8 after release", 4'b1111);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(TBL[i]);
         @(negedge clk);
         check($sformatf("R2..R6 row %0d", i), TBL[i].ex);
      end

      // R8: a change is not visible before the next rising edge
      @(negedge clk);
      apply(TBL[0]);
      #2;
      check("R8 hold", TBL[NV-1].ex);
      @(negedge clk);
      check("R8 update", 4'b0000);

      // R4: offset alone carries guest time past compare
      rt_count = 64'd10; time_ofs = 64'd90; vt_cmp = 64'd100;
      @(negedge clk);
      check("R4 offset", 4'b0010);

      // R1: reset asserted again mid-run clears outputs
      apply(TBL[NV-1]);
      @(negedge clk);
      rst_n = 0;
      #2;
      check("R1 async", 4'b0000);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R6 R2 R5 R4 after rereset", 4'b1111);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule